// File: doc/BRIEF.md
# Word Reduction and Sign-Spread Unit

This block is a small arithmetic sub-unit that collapses a 32-bit operand into a single truth value and returns that value spread across the whole word. It offers three whole-word tests: every bit set, any bit set, and odd bit parity. It also offers a fourth operation that fills the result with copies of the operand's top bit. A true result is returned as all ones (-1) and a false result as all zeros. With this encoding, a bitwise NOT of any result gives its logical complement, and the sign-spread result equals an arithmetic right shift of the operand by 31.

Operands arrive on a valid/ready input stream together with a 2-bit operation code. Results leave on a valid/ready output stream after one register stage. A transfer happens on a rising clock edge where both valid and ready are high. The input is ready whenever the output register is empty or is being drained in the same cycle. While the output is valid and the consumer holds ready low, the result word stays frozen and no new operand is taken. An operand may be accepted in the same cycle that the previous result is drained, so the unit can sustain one operation per clock.

Top module: `redsign_unit`

## Requirements
- R1: With operation code 2'b00 (all-set test), the result is 32'hFFFFFFFF when every operand bit is 1, and 32'h00000000 otherwise.
- R2: With operation code 2'b01 (any-set test), the result is 32'hFFFFFFFF when at least one operand bit is 1, and 32'h00000000 otherwise.
- R3: With operation code 2'b10 (parity test), the result is 32'hFFFFFFFF when the operand has an odd number of 1 bits, and 32'h00000000 otherwise.
- R4: With operation code 2'b11 (sign spread), every result bit equals operand bit 31, which is the same value as an arithmetic right shift of the operand by 31.
- R5: Every valid result is either all zeros or all ones, so that its bitwise NOT is the opposite truth value.
- R6: An operand accepted at a clock edge appears as a valid result after exactly that edge. If nothing new is accepted while a result is drained, out_valid falls after that edge.
- R7: While out_valid is high and out_ready is low, in_ready is low, out_valid stays high and out_word does not change. An in_valid offered in that time is not consumed.
- R8: While rst_n is low, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand and operation code are offered |
| in_ready | output | 1 | Unit can take an operand this cycle |
| in_word | input | 32 | Operand |
| in_op | input | 2 | Operation: 00 all-set, 01 any-set, 10 parity, 11 sign spread |
| out_valid | output | 1 | out_word holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_word | output | 32 | Result, all ones or all zeros |

## Verification
Each result is due one clock after its operand is accepted. The bench drives inputs on the falling edge and reads out_valid and out_word on the next falling edge, which falls between the capturing rising edge and the following one. Under back-pressure the same result must still be present one and two cycles later, and the operand that was held back must appear one cycle after out_ready returns. Result values are checked against independently computed expressions for the boundary operands 0, -1, 32'h80000000 and 32'h7FFFFFFF and for a set of fixed mixed patterns.

// File: rtl/redsign_pkg.sv
package redsign_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned OP_W   = 2;

  typedef enum logic [OP_W-1:0] {
    OP_ALLSET = 2'b00,
    OP_ANYSET = 2'b01,
    OP_PARITY = 2'b10,
    OP_SPREAD = 2'b11
  } redop_e;
endpackage

// File: rtl/redsign_core.sv
module redsign_core
  import redsign_pkg::*;
#(
  parameter int unsigned WIDTH = WORD_W
) (
  input  logic [WIDTH-1:0] opnd,
  input  redop_e           op,
  output logic [WIDTH-1:0] result
);
  localparam int unsigned MSB = WIDTH - 1;

  logic truth;

  always_comb begin
    unique case (op)
      OP_ALLSET: truth = &opnd;
      OP_ANYSET: truth = |opnd;
      OP_PARITY: truth = ^opnd;
      OP_SPREAD: truth = opnd[MSB];
      default:   truth = 1'b0;
    endcase
  end

  // Spread the single truth bit across the word so that NOT inverts it.
  for (genvar b = 0; b < WIDTH; b++) begin : g_fan
    assign result[b] = truth;
  end
endmodule

// File: rtl/redsign_stage.sv
module redsign_stage #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      out_data <= in_data;
    end
  end

  assert_reset_R8: assert property (@(posedge clk) !rst_n |=> !out_valid);

  assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: rtl/redsign_unit.sv
module redsign_unit
  import redsign_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  logic [OP_W-1:0]   in_op,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word
);
  localparam int unsigned SHIFT = WORD_W - 1;
  localparam logic [WORD_W-1:0] ONES = '1;

  logic [WORD_W-1:0] comb_res;

  redsign_core #(.WIDTH(WORD_W)) u_core (
    .opnd   (in_word),
    .op     (redop_e'(in_op)),
    .result (comb_res)
  );

  redsign_stage #(.WIDTH(WORD_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (comb_res),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_word)
  );

  assert_uniform_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_word == '0 || out_word == ONES));

  assert_allset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op == 2'b00) |=>
      (out_word == (($past(in_word) == ONES) ? ONES : '0)));

  assert_anyset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op == 2'b01) |=>
      (out_word == (($past(in_word) != '0) ? ONES : '0)));

  assert_parity_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op == 2'b10) |=>
      (out_word[0] == $past($countones(in_word) % 2 == 1)));

  assert_spread_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op == 2'b11) |=>
      (out_word == WORD_W'($signed($past(in_word)) >>> SHIFT)));
endmodule

// File: tb/redsign_unit_test.sv
module redsign_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic [1:0]  in_op = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_word;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  redsign_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_op(in_op), .out_valid(out_valid),
    .out_ready(out_ready), .out_word(out_word)
  );

  function automatic logic [31:0] model(input logic [31:0] w, input logic [1:0] op);
    int ones = 0;
    for (int i = 0; i < 32; i++) ones += w[i];
    case (op)
      2'b00:   return (ones == 32) ? 32'hFFFF_FFFF : 32'h0;
      2'b01:   return (ones != 0) ? 32'hFFFF_FFFF : 32'h0;
      2'b10:   return (ones % 2 == 1) ? 32'hFFFF_FFFF : 32'h0;
      default: return w[31] ? 32'hFFFF_FFFF : 32'h0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      finish_run();
    end
  end

  // One operation, consumer always ready; result checked one cycle later.
  task automatic run_op(input string req, input logic [31:0] w, input logic [1:0] op);
    @(negedge clk);
    in_valid = 1'b1; in_word = w; in_op = op; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid"}, {31'b0, out_valid}, 32'h1);
    chk(req, out_word, model(w, op));
    chk("R5 inverse", ~out_word, ~model(w, op));
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 out_valid", {31'b0, out_valid}, 32'h0);
    chk("R8 in_ready", {31'b0, in_ready}, 32'h1);
    rst_n = 1'b1;
  endtask

  task automatic test_values();
    logic [31:0] pats[8] = '{32'h0, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF,
                             32'h0000_0001, 32'hA5A5_1234, 32'hFFFF_FFFE, 32'h0F0F_0F0E};
    foreach (pats[k]) begin
      run_op("R1 allset", pats[k], 2'b00);
      run_op("R2 anyset", pats[k], 2'b01);
      run_op("R3 parity", pats[k], 2'b10);
      run_op("R4 spread", pats[k], 2'b11);
      chk("R4 shift", out_word, 32'($signed(pats[k]) >>> 31));
    end
  endtask

  task automatic test_drain();
    run_op("R6 accept", 32'h0000_0003, 2'b01);
    @(negedge clk);
    chk("R6 drained", {31'b0, out_valid}, 32'h0);
  endtask

  task automatic test_backpressure();
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_word = 32'h8000_0000; in_op = 2'b11;
    @(negedge clk);
    chk("R7 first valid", {31'b0, out_valid}, 32'h1);
    chk("R7 first value", out_word, 32'hFFFF_FFFF);
    in_word = 32'h0000_0000; in_op = 2'b01;
    chk("R7 in_ready low", {31'b0, in_ready}, 32'h0);
    @(negedge clk);
    chk("R7 still valid", {31'b0, out_valid}, 32'h1);
    chk("R7 held value", out_word, 32'hFFFF_FFFF);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7 next valid", {31'b0, out_valid}, 32'h1);
    chk("R7 next value", out_word, 32'h0);
    @(negedge clk);
    chk("R6 empty", {31'b0, out_valid}, 32'h0);
  endtask

  task automatic test_stream();
    logic [31:0] ws[4] = '{32'h1, 32'h3, 32'hFFFF_FFFF, 32'h7FFF_FFFF};
    logic [1:0]  os[4] = '{2'b10, 2'b10, 2'b00, 2'b11};
    @(negedge clk);
    out_ready = 1'b1;
    for (int k = 0; k < 4; k++) begin
      in_valid = 1'b1; in_word = ws[k]; in_op = os[k];
      @(negedge clk);
      chk("R6 stream valid", {31'b0, out_valid}, 32'h1);
      chk("R6 stream value", out_word, model(ws[k], os[k]));
    end
    in_valid = 1'b0;
  endtask

  initial begin
    test_reset();
    test_values();
    test_drain();
    test_backpressure();
    test_stream();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule